// File: doc/BRIEF.md
# Even-Ratio Clock Divider with Binary Taps

This block derives slower periodic signals from one fast input clock. It has two independent sections. A free-running binary counter presents all of its bits as taps, and each higher bit runs at half the rate of the one below it. Beside it, a programmable section produces one square wave whose period is any even number of input cycles, 2m, with equal high and low times.

The programmable section counts input cycles modulo m. It raises a one-cycle wrap pulse in the last cycle of each count, and that pulse drives a toggle stage that inverts the square-wave output on the next edge. The ratio m comes from a runtime input. It is sampled only at a wrap and at reset, so a change in the middle of a half-period never cuts that half-period short. A ratio input of zero is treated as one. The outputs are ordinary logic signals meant to be sampled by logic in the same clock domain, and are not intended to drive clock trees.

Top module: `even_clk_divider`

## Requirements
- R1: On each clock edge with reset low, taps_o increases by one modulo 2^TAP_W. Reset sets it to 0.
- R2: Bit i of taps_o toggles once every 2^i input cycles, so it runs at the input rate divided by 2^(i+1).
- R3: wrap_o is high for exactly one cycle in each half-period of div_o, the last cycle before div_o changes. div_o inverts on every edge where wrap_o is high.
- R4: For a steady ratio m with 1 <= m <= 2^RATIO_W-1, div_o stays high for exactly m cycles and low for exactly m cycles, giving a period of 2m.
- R5: A ratio_i value of 0 gives the same output as a value of 1, which is a square wave at half the input rate.
- R6: ratio_i is sampled only at the edge that ends a half-period. A change in ratio_i during a half-period leaves the length of that half-period unchanged, and the following half-period uses the new value.
- R7: Reset is synchronous and active high. An edge with rst high clears taps_o, div_o, wrap_o and the modulo count, and loads ratio_i as the ratio. After release, div_o is low for the first m cycles.
- R8: On every edge where wrap_o is low, div_o keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst | input | 1 | Synchronous reset, active high |
| ratio_i | input | RATIO_W | Half-period length m in input cycles (0 acts as 1) |
| taps_o | output | TAP_W | Free-running counter bits, bit i at f/2^(i+1) |
| div_o | output | 1 | Square wave at f/(2m) with 50% duty |
| wrap_o | output | 1 | One-cycle pulse at the end of each modulo-m count |

## Verification
The hardest situation to create from the ports is a ratio change that arrives partway through a half-period. If the divider sampled ratio_i at the wrong moment, that half-period would be shortened or stretched. The stimulus first locks onto an edge of div_o, then waits a known number of cycles, and then changes ratio_i in both directions. It measures the remaining length of the current half-period, which must follow the old ratio, and the length of the next one, which must follow the new ratio. A reset applied during a running half-period is also checked, to confirm that the phase and the ratio restart from the value on ratio_i.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int DEF_TAP_W   = 4;
    localparam int DEF_RATIO_W = 8;

    typedef enum logic {
        LEVEL_LOW  = 1'b0,
        LEVEL_HIGH = 1'b1
    } level_e;
endpackage

// File: rtl/tap_counter.sv
module tap_counter #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] taps_o
);
    localparam logic [WIDTH-1:0] STEP = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } tap_state_t;

    tap_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + STEP;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign taps_o = st_q.cnt;
endmodule

// File: rtl/modulo_counter.sv
module modulo_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] ratio_i,
    output logic             wrap_o,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] ratio_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] ratio;
    } mod_state_t;

    mod_state_t       st_d, st_q;
    logic [WIDTH-1:0] ratio_eff;
    logic             at_end;

    always_comb begin
        ratio_eff = (ratio_i == '0) ? ONE : ratio_i;
        at_end    = (st_q.cnt == (st_q.ratio - ONE));
        st_d      = st_q;
        if (rst) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_eff;
        end else if (at_end) begin
            st_d.cnt   = '0;
            st_d.ratio = ratio_eff;
        end else begin
            st_d.cnt   = st_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign wrap_o  = at_end && !rst;
    assign cnt_o   = st_q.cnt;
    assign ratio_o = st_q.ratio;
endmodule

// File: rtl/toggle_stage.sv
module toggle_stage
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic t_i,
    output logic q_o
);
    typedef struct packed {
        level_e lvl;
    } tog_state_t;

    tog_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.lvl = LEVEL_LOW;
        end else if (t_i) begin
            st_d.lvl = (st_q.lvl == LEVEL_HIGH) ? LEVEL_LOW : LEVEL_HIGH;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_o = (st_q.lvl == LEVEL_HIGH);
endmodule

// File: rtl/even_clk_divider.sv
module even_clk_divider #(
    parameter int TAP_W   = clkdiv_pkg::DEF_TAP_W,
    parameter int RATIO_W = clkdiv_pkg::DEF_RATIO_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic [TAP_W-1:0]   taps_o,
    output logic               div_o,
    output logic               wrap_o
);
    logic [RATIO_W-1:0] mod_cnt;
    logic [RATIO_W-1:0] ratio_cur;
    logic               wrap_w;

    tap_counter #(.WIDTH(TAP_W)) u_taps (
        .clk    (clk),
        .rst    (rst),
        .taps_o (taps_o)
    );

    modulo_counter #(.WIDTH(RATIO_W)) u_mod (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (ratio_i),
        .wrap_o  (wrap_w),
        .cnt_o   (mod_cnt),
        .ratio_o (ratio_cur)
    );

    toggle_stage u_tog (
        .clk (clk),
        .rst (rst),
        .t_i (wrap_w),
        .q_o (div_o)
    );

    assign wrap_o = wrap_w;
endmodule

// File: rtl/clkdiv_checker.sv
module clkdiv_checker #(
    parameter int TAP_W   = 4,
    parameter int RATIO_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic [TAP_W-1:0]   taps_o,
    input logic               div_o,
    input logic               wrap_o,
    input logic [RATIO_W-1:0] mod_cnt,
    input logic [RATIO_W-1:0] ratio_cur
);
    AST_TAP_STEP: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (taps_o == $past(taps_o) + TAP_W'(1))); // R1

    AST_WRAP_TOGGLES: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> (div_o != $past(div_o))); // R3

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> $stable(div_o)); // R8

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (mod_cnt < ratio_cur)); // R4

    AST_RATIO_NONZERO: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (ratio_cur != '0)); // R5

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wrap_o |=> $stable(ratio_cur)); // R6
endmodule

bind even_clk_divider clkdiv_checker #(
    .TAP_W   (TAP_W),
    .RATIO_W (RATIO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .taps_o    (taps_o),
    .div_o     (div_o),
    .wrap_o    (wrap_o),
    .mod_cnt   (mod_cnt),
    .ratio_cur (ratio_cur)
);

// File: tb/sim_even_clk_divider.sv
`timescale 1ns/1ps
module sim_even_clk_divider;
    localparam int TAP_W   = 4;
    localparam int RATIO_W = 8;
    localparam int HALF_NS = 10;

    typedef struct packed {
        int ratio;
        int half;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{1, 1}, '{0, 1}, '{2, 2}, '{3, 3}, '{6, 6}, '{17, 17}, '{255, 255}
    };

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [RATIO_W-1:0] ratio_i = 8'd3;
    logic [TAP_W-1:0]   taps_o;
    logic               div_o;
    logic               wrap_o;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(HALF_NS) clk = ~clk;

    even_clk_divider #(.TAP_W(TAP_W), .RATIO_W(RATIO_W)) u0 (
        .clk     (clk),
        .rst     (rst),
        .ratio_i (ratio_i),
        .taps_o  (taps_o),
        .div_o   (div_o),
        .wrap_o  (wrap_o)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic sync_edge();
        logic prev;
        prev = div_o;
        do @(negedge clk); while (div_o == prev);
    endtask

    task automatic measure(output int len, output int wraps, output int lvl);
        logic prev;
        prev  = div_o;
        lvl   = int'(div_o);
        len   = 0;
        wraps = 0;
        forever begin
            if (wrap_o) wraps++;
            len++;
            @(negedge clk);
            if (div_o != prev) break;
        end
    endtask

    initial begin
        #(2 * HALF_NS * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int len, wraps, lvl, base;

        // R7: reset state
        rst = 1'b1;
        ratio_i = 8'd3;
        repeat (2) @(negedge clk);
        chk("R7 taps at reset", int'(taps_o), 0);
        chk("R7 div at reset", int'(div_o), 0);
        chk("R7 wrap at reset", int'(wrap_o), 0);
        rst = 1'b0;
        measure(len, wraps, lvl);
        chk("R7 first half level", lvl, 0);
        chk("R7 first half length", len, 3);

        // R1: counter steps by one and wraps
        base = int'(taps_o);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            chk("R1 tap value", int'(taps_o), (base + k) % (1 << TAP_W));
        end

        // R2: per-bit toggle rate over 64 cycles
        begin
            int tog [TAP_W];
            logic [TAP_W-1:0] prev;
            for (int i = 0; i < TAP_W; i++) tog[i] = 0;
            prev = taps_o;
            for (int c = 0; c < 64; c++) begin
                @(negedge clk);
                for (int i = 0; i < TAP_W; i++)
                    if (taps_o[i] != prev[i]) tog[i]++;
                prev = taps_o;
            end
            for (int i = 0; i < TAP_W; i++)
                chk("R2 tap toggle count", tog[i], 64 >> i);
        end

        // R3 R4 R5: steady ratios from the vector table
        for (int v = 0; v < 7; v++) begin
            ratio_i = RATIO_W'(VECS[v].ratio);
            sync_edge();
            sync_edge();
            for (int h = 0; h < 2; h++) begin
                measure(len, wraps, lvl);
                chk(VECS[v].ratio == 0 ? "R5 zero ratio half" : "R4 half length",
                    len, VECS[v].half);
                chk("R3 wraps per half", wraps, 1);
            end
        end

        // R6: decrease mid half-period
        ratio_i = 8'd8;
        sync_edge();
        sync_edge();
        repeat (2) @(negedge clk);
        ratio_i = 8'd2;
        measure(len, wraps, lvl);
        chk("R6 old half kept (down)", len, 6);
        measure(len, wraps, lvl);
        chk("R6 new ratio used (down)", len, 2);

        // R6: increase mid half-period
        sync_edge();
        @(negedge clk);
        ratio_i = 8'd9;
        measure(len, wraps, lvl);
        chk("R6 old half kept (up)", len, 1);
        measure(len, wraps, lvl);
        chk("R6 new ratio used (up)", len, 9);

        // R7: reset in the middle of a run
        ratio_i = 8'd5;
        sync_edge();
        sync_edge();
        repeat (2) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk("R7 mid reset taps", int'(taps_o), 0);
        chk("R7 mid reset div", int'(div_o), 0);
        @(negedge clk);
        rst = 1'b0;
        measure(len, wraps, lvl);
        chk("R7 restart level", lvl, 0);
        chk("R7 restart length", len, 5);
        measure(len, wraps, lvl);
        chk("R7 second half level", lvl, 1);
        chk("R7 second half length", len, 5);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule